// File: doc/BRIEF.md
# DDR Read Burst Sequencer

This block turns a READ command into the read data stream of a double-data-rate interface. On each command it walks the columns of the burst in sequential or interleaved order. It fetches one 64-bit prefetch word per clock from a synchronous memory array. It then splits each word into a rising-half word and a falling-half word, delayed by the programmed CAS latency. A matching strobe enable is produced for every byte lane, with a one-clock low preamble ahead of each run of data.

A controller feeds the block the command, the start column and the programmed burst settings. The block drives the address and read enable of the array, and the array returns the word one clock later. A burst-terminate pulse or a fresh READ cuts the current burst short. Data that was already fetched still drains out at its latency, so the stream stays seamless.

Top module: `rdseq_top`

## Requirements
- R1: While `rst` is high, `dq_valid`, `dqs_pre`, `dqs_oe`, `mem_rd_en`, `dq_rise` and `dq_fall` are all zero.
- R2: With `cfg_cl3` low, the first data of a READ sampled at clock edge T appears in the cycle that starts at edge T+2. With `cfg_cl3` high, it appears at edge T+3.
- R3: `cfg_bl` codes 1, 2 and 3 select burst lengths of 2, 4 and 8 beats, which is 1, 2 or 4 clocks of valid data. Code 0 behaves as 2.
- R4: In sequential order (`cfg_ilv` low), beat k of a burst of length BL starting at column c reads column (c & ~(BL-1)) | ((c+k) mod BL), wrapping inside the aligned block.
- R5: In interleaved order (`cfg_ilv` high), beat k reads column (c & ~(BL-1)) | ((c XOR k) & (BL-1)).
- R6: Column n occupies bits [32*(n%2)+31 : 32*(n%2)] of memory word n/2. Even beats go out on `dq_rise` and odd beats on `dq_fall`.
- R7: Bit 0 of `rd_col` is ignored; a burst always starts on the even column below it.
- R8: A `bst` pulse at edge B with no READ stops fetching. The last data appears in the cycle starting at edge B-1+CL, and no data follows from the cycle starting at edge B+CL.
- R9: A READ during a burst truncates it. Beats already fetched still appear. The new burst follows at its own latency without a gap.
- R10: `dqs_pre` is high, with `dqs_oe` all ones, in the clock before the first beat of every run of valid data. `dqs_oe` stays all ones while `dq_valid` is high, and `dqs_pre` is never high together with `dq_valid`.
- R11: When `dq_valid` is low, `dq_rise` and `dq_fall` are zero.
- R12: Burst length and type are captured with the READ, so changing `cfg_bl` or `cfg_ilv` during a burst has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_cmd | input | 1 | READ command strobe |
| rd_col | input | 9 | Start column of the READ |
| cfg_cl3 | input | 1 | CAS latency: 0 gives 2 clocks, 1 gives 3 clocks |
| cfg_bl | input | 2 | Burst length code |
| cfg_ilv | input | 1 | Burst order: 0 sequential, 1 interleaved |
| bst | input | 1 | Burst terminate pulse |
| mem_rd_en | output | 1 | Array read enable |
| mem_addr | output | 8 | Array word address |
| mem_rdata | input | 64 | Array word, one clock after the address |
| dq_rise | output | 32 | Data for the rising half of the clock |
| dq_fall | output | 32 | Data for the falling half of the clock |
| dq_valid | output | 1 | Data valid |
| dqs_oe | output | 4 | Strobe enable, one per byte lane |
| dqs_pre | output | 1 | Strobe held low as preamble |

## Verification
Some properties are checked on every cycle:
- The fetch address never leaves the aligned block of the burst.
- Output data always follows a fetch by exactly the latency.
- A terminate empties the output after CL clocks.
- The preamble precedes every data run and never overlaps data.
- The lane enables cover every data cycle.

Other behaviour can only be shown by the bench's scenarios, which compare the data against a column model:
- the exact column order in both burst types across alignments,
- the burst lengths,
- the ignored column bit,
- the truncation by a second READ,
- the immunity to a configuration change during a burst.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;
  localparam int MAX_BEATS = 8;
  localparam int MAX_WORDS = MAX_BEATS / 2;
  localparam int OFF_W     = $clog2(MAX_WORDS);

  typedef logic [OFF_W-1:0] off_t;

  typedef enum logic [1:0] {
    BL_CODE_RSVD  = 2'd0,
    BL_CODE_TWO   = 2'd1,
    BL_CODE_FOUR  = 2'd2,
    BL_CODE_EIGHT = 2'd3
  } blen_e;

  // word-offset mask of a burst: words per burst minus one
  function automatic off_t span_mask(logic [1:0] code);
    case (blen_e'(code))
      BL_CODE_FOUR:  return off_t'(1);
      BL_CODE_EIGHT: return off_t'(3);
      default:       return '0;
    endcase
  endfunction
endpackage

// File: rtl/rdseq_addr_gen.sv
module rdseq_addr_gen
  import rdseq_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_cmd,
  input  logic [COL_W-1:0] rd_col,
  input  logic [1:0]       cfg_bl,
  input  logic             cfg_ilv,
  input  logic             bst,
  output logic             mem_rd_en,
  output logic [COL_W-2:0] mem_addr
);
  localparam int WA_W = COL_W - 1;

  logic            act_q;
  off_t            beat_q;
  off_t            mask_q;
  logic            ilv_q;
  logic [WA_W-1:0] start_q;
  logic [WA_W-1:0] mask_ext;
  logic            unused_col_lsb;

  assign unused_col_lsb = rd_col[0];
  assign mask_ext = {{(WA_W-OFF_W){1'b0}}, mask_q};

  function automatic logic [WA_W-1:0] word_at(logic [WA_W-1:0] s, off_t j,
                                               off_t m, logic il);
    off_t            o;
    logic [WA_W-1:0] me;
    o  = il ? (s[OFF_W-1:0] ^ j) : (s[OFF_W-1:0] + j);
    me = {{(WA_W-OFF_W){1'b0}}, m};
    return (s & ~me) | ({{(WA_W-OFF_W){1'b0}}, o} & me);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q     <= 1'b0;
      beat_q    <= '0;
      mask_q    <= '0;
      ilv_q     <= 1'b0;
      start_q   <= '0;
      mem_rd_en <= 1'b0;
      mem_addr  <= '0;
    end else if (rd_cmd) begin
      start_q   <= rd_col[COL_W-1:1];
      mask_q    <= span_mask(cfg_bl);
      ilv_q     <= cfg_ilv;
      mem_addr  <= rd_col[COL_W-1:1];
      mem_rd_en <= 1'b1;
      beat_q    <= off_t'(1);
      act_q     <= (span_mask(cfg_bl) != '0);
    end else if (act_q && !bst) begin
      mem_addr  <= word_at(start_q, beat_q, mask_q, ilv_q);
      mem_rd_en <= 1'b1;
      beat_q    <= beat_q + off_t'(1);
      act_q     <= (beat_q != mask_q);
    end else begin
      mem_rd_en <= 1'b0;
      act_q     <= 1'b0;
    end
  end

  AST_STAY_IN_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && !$past(rd_cmd)) |->
      ($past(mem_rd_en) && (((mem_addr ^ $past(mem_addr)) & ~mask_ext) == '0))); // R4
endmodule

// File: rtl/rdseq_data_pipe.sv
module rdseq_data_pipe #(
  parameter int DQ_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_cl3,
  input  logic              mem_rd_en,
  input  logic [2*DQ_W-1:0] mem_rdata,
  output logic              lead_v,
  output logic              due_v,
  output logic [DQ_W-1:0]   dq_rise,
  output logic [DQ_W-1:0]   dq_fall,
  output logic              dq_valid
);
  localparam int PW = 2 * DQ_W;

  logic          ret_v_q;
  logic          stg_v_q;
  logic [PW-1:0] stg_d_q;
  logic [PW-1:0] sel_d;

  assign due_v  = cfg_cl3 ? stg_v_q : ret_v_q;
  assign lead_v = cfg_cl3 ? ret_v_q : mem_rd_en;
  assign sel_d  = cfg_cl3 ? stg_d_q : mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_v_q  <= 1'b0;
      stg_v_q  <= 1'b0;
      stg_d_q  <= '0;
      dq_valid <= 1'b0;
      dq_rise  <= '0;
      dq_fall  <= '0;
    end else begin
      ret_v_q  <= mem_rd_en;
      stg_v_q  <= ret_v_q;
      stg_d_q  <= mem_rdata;
      dq_valid <= due_v;
      dq_rise  <= due_v ? sel_d[DQ_W-1:0]  : '0;
      dq_fall  <= due_v ? sel_d[PW-1:DQ_W] : '0;
    end
  end

  AST_LATENCY_CL2: assert property (@(posedge clk) disable iff (rst)
    (dq_valid && !cfg_cl3) |-> $past(mem_rd_en, 2)); // R2
  AST_LATENCY_CL3: assert property (@(posedge clk) disable iff (rst)
    (dq_valid && cfg_cl3) |-> $past(mem_rd_en, 3)); // R2
endmodule

// File: rtl/rdseq_strobe_ctl.sv
module rdseq_strobe_ctl #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lead_v,
  input  logic             due_v,
  output logic [LANES-1:0] dqs_oe,
  output logic             dqs_pre
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dqs_oe  <= '0;
      dqs_pre <= 1'b0;
    end else begin
      dqs_oe  <= {LANES{lead_v | due_v}};
      dqs_pre <= lead_v & ~due_v;
    end
  end
endmodule

// File: rtl/rdseq_top.sv
module rdseq_top #(
  parameter int DQ_W  = 32,
  parameter int COL_W = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_cmd,
  input  logic [COL_W-1:0]    rd_col,
  input  logic                cfg_cl3,
  input  logic [1:0]          cfg_bl,
  input  logic                cfg_ilv,
  input  logic                bst,
  output logic                mem_rd_en,
  output logic [COL_W-2:0]    mem_addr,
  input  logic [2*DQ_W-1:0]   mem_rdata,
  output logic [DQ_W-1:0]     dq_rise,
  output logic [DQ_W-1:0]     dq_fall,
  output logic                dq_valid,
  output logic [DQ_W/8-1:0]   dqs_oe,
  output logic                dqs_pre
);
  localparam int LANES = DQ_W / 8;

  logic lead_v;
  logic due_v;

  rdseq_addr_gen #(.COL_W(COL_W)) u_agen (
    .clk(clk), .rst(rst), .rd_cmd(rd_cmd), .rd_col(rd_col),
    .cfg_bl(cfg_bl), .cfg_ilv(cfg_ilv), .bst(bst),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr)
  );

  rdseq_data_pipe #(.DQ_W(DQ_W)) u_dpipe (
    .clk(clk), .rst(rst), .cfg_cl3(cfg_cl3), .mem_rd_en(mem_rd_en),
    .mem_rdata(mem_rdata), .lead_v(lead_v), .due_v(due_v),
    .dq_rise(dq_rise), .dq_fall(dq_fall), .dq_valid(dq_valid)
  );

  rdseq_strobe_ctl #(.LANES(LANES)) u_strb (
    .clk(clk), .rst(rst), .lead_v(lead_v), .due_v(due_v),
    .dqs_oe(dqs_oe), .dqs_pre(dqs_pre)
  );

  AST_BST_DRAIN_CL2: assert property (@(posedge clk) disable iff (rst)
    (bst && !rd_cmd && !cfg_cl3) |-> ##3 !dq_valid); // R8
  AST_BST_DRAIN_CL3: assert property (@(posedge clk) disable iff (rst)
    (bst && !rd_cmd && cfg_cl3) |-> ##4 !dq_valid); // R8
  AST_PREAMBLE_LEADS: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_valid) |-> $past(dqs_pre)); // R10
  AST_PRE_APART: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dqs_pre, dq_valid})); // R10
  AST_LANES_ON: assert property (@(posedge clk) disable iff (rst)
    dq_valid |-> (dqs_oe == {LANES{1'b1}})); // R10
endmodule

// File: tb/sim_rdseq_top.sv
module sim_rdseq_top;
  localparam int DQ_W  = 32;
  localparam int COL_W = 9;
  localparam int WORDS = 1 << (COL_W - 1);

  typedef struct {
    int          cyc;
    logic [31:0] r;
    logic [31:0] f;
    string       req;
  } item_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              rd_cmd = 1'b0;
  logic [COL_W-1:0]  rd_col = '0;
  logic              cfg_cl3 = 1'b0;
  logic [1:0]        cfg_bl = 2'd1;
  logic              cfg_ilv = 1'b0;
  logic              bst = 1'b0;
  logic              mem_rd_en;
  logic [COL_W-2:0]  mem_addr;
  logic [2*DQ_W-1:0] mem_rdata = '0;
  logic [DQ_W-1:0]   dq_rise;
  logic [DQ_W-1:0]   dq_fall;
  logic              dq_valid;
  logic [DQ_W/8-1:0] dqs_oe;
  logic              dqs_pre;

  logic [2*DQ_W-1:0] mem [WORDS];
  item_t             sbq[$];
  int                cyc = 0;
  int                n_chk = 0;
  int                n_bad = 0;
  logic              prev_v = 1'b0;
  logic              prev_pre = 1'b0;

  always #10 clk = ~clk;

  rdseq_top #(.DQ_W(DQ_W), .COL_W(COL_W)) u0 (
    .clk(clk), .rst(rst), .rd_cmd(rd_cmd), .rd_col(rd_col),
    .cfg_cl3(cfg_cl3), .cfg_bl(cfg_bl), .cfg_ilv(cfg_ilv), .bst(bst),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .dq_rise(dq_rise), .dq_fall(dq_fall), .dq_valid(dq_valid),
    .dqs_oe(dqs_oe), .dqs_pre(dqs_pre)
  );

  function automatic logic [31:0] cv(int c);
    return 32'hC000_0007 | (32'(c) << 4);
  endfunction

  function automatic int beat_col(int c, int bl, bit il, int k);
    int c0, base;
    c0   = c & ~1;                 // R7
    base = c0 & ~(bl - 1);
    return il ? (base | ((c0 ^ k) & (bl - 1)))   // R5
              : (base | ((c0 + k) & (bl - 1)));  // R4
  endfunction

  initial begin
    for (int w = 0; w < WORDS; w++) mem[w] = {cv(2*w+1), cv(2*w)}; // R6
  end

  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, logic [95:0] act, logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cut(int lim);
    while (sbq.size() > 0 && sbq[$].cyc >= lim) void'(sbq.pop_back());
  endtask

  task automatic issue_rd(int col, int code, bit il, string req);
    int bl, cl, t;
    item_t it;
    bl = (code == 2) ? 4 : (code == 3) ? 8 : 2;   // R3
    cl = cfg_cl3 ? 3 : 2;
    t  = cyc + 1;
    cut(t + cl);                                   // R9
    for (int j = 0; j < bl/2; j++) begin
      it.cyc = t + cl + j;                         // R2
      it.r   = cv(beat_col(col, bl, il, 2*j));
      it.f   = cv(beat_col(col, bl, il, 2*j + 1));
      it.req = req;
      sbq.push_back(it);
    end
    rd_cmd  = 1'b1;
    rd_col  = COL_W'(col);
    cfg_bl  = 2'(code);
    cfg_ilv = il;
    @(negedge clk);
    rd_cmd = 1'b0;
  endtask

  task automatic do_bst();
    cut(cyc + 1 + (cfg_cl3 ? 3 : 2));              // R8
    bst = 1'b1;
    @(negedge clk);
    bst = 1'b0;
  endtask

  task automatic drain();
    wait (sbq.size() == 0);
    repeat (5) @(negedge clk);
  endtask

  // monitor: compares outputs against the scoreboard away from the clock edge
  always @(negedge clk) begin
    if (!rst) begin
      while (sbq.size() > 0 && sbq[0].cyc < cyc) begin
        check(1'b0, sbq[0].req, "missing beat", 96'(0), {32'(sbq[0].cyc), sbq[0].r, sbq[0].f});
        void'(sbq.pop_front());
      end
      if (dq_valid) begin
        if (sbq.size() == 0 || sbq[0].cyc != cyc) begin
          check(1'b0, "R9", "unexpected beat", {32'(cyc), dq_rise, dq_fall}, 96'(0));
        end else begin
          check(dq_rise == sbq[0].r && dq_fall == sbq[0].f, sbq[0].req, "R2 beat",
                {32'(cyc), dq_rise, dq_fall}, {32'(sbq[0].cyc), sbq[0].r, sbq[0].f});
          void'(sbq.pop_front());
        end
        check(dqs_oe == '1 && !dqs_pre, "R10", "lanes during data",
              96'({dqs_oe, dqs_pre}), 96'({4'hF, 1'b0}));
        if (!prev_v)
          check(prev_pre, "R10", "preamble before run", 96'(prev_pre), 96'(1));
      end else begin
        if (sbq.size() > 0 && sbq[0].cyc == cyc) begin
          check(1'b0, sbq[0].req, "missing beat", 96'(0), {32'(sbq[0].cyc), sbq[0].r, sbq[0].f});
          void'(sbq.pop_front());
        end
        check(dq_rise == '0 && dq_fall == '0, "R11", "idle data",
              {32'(0), dq_rise, dq_fall}, 96'(0));
      end
      prev_v   = dq_valid;
      prev_pre = dqs_pre;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R2 watchdog: actual 50000 cycles expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!dq_valid && !dqs_pre && dqs_oe == '0 && !mem_rd_en && dq_rise == '0 && dq_fall == '0,
          "R1", "reset state",
          96'({dq_valid, dqs_pre, dqs_oe, mem_rd_en, dq_rise}), 96'(0));
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // latency 2
    issue_rd(10, 1, 1'b0, "R3");  drain();
    issue_rd(6,  2, 1'b0, "R4");  drain();
    issue_rd(12, 3, 1'b0, "R4");  drain();
    issue_rd(18, 3, 1'b0, "R4");  drain();
    issue_rd(18, 3, 1'b1, "R5");  drain();
    issue_rd(34, 2, 1'b1, "R5");  drain();
    issue_rd(13, 2, 1'b0, "R7");  drain();
    issue_rd(40, 0, 1'b0, "R3");  drain();
    issue_rd(200, 3, 1'b0, "R6"); drain();

    // terminate after one and after two fetches
    issue_rd(64, 3, 1'b0, "R8"); do_bst(); drain();
    issue_rd(64, 3, 1'b1, "R8"); @(negedge clk); do_bst(); drain();

    // truncation by a second read, back-to-back reads
    issue_rd(80, 3, 1'b0, "R9"); issue_rd(98, 2, 1'b1, "R9"); drain();
    issue_rd(120, 1, 1'b0, "R9"); issue_rd(122, 1, 1'b0, "R9"); issue_rd(124, 1, 1'b0, "R9"); drain();

    // configuration changed during a burst
    issue_rd(140, 3, 1'b1, "R12");
    cfg_bl = 2'd1; cfg_ilv = 1'b0;
    drain();

    // latency 3
    cfg_cl3 = 1'b1;
    repeat (3) @(negedge clk);
    issue_rd(42, 3, 1'b1, "R2");  drain();
    issue_rd(102, 2, 1'b0, "R2"); drain();
    issue_rd(150, 3, 1'b0, "R8"); @(negedge clk); do_bst(); drain();
    issue_rd(160, 3, 1'b0, "R9"); @(negedge clk); issue_rd(171, 3, 1'b1, "R9"); drain();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule